// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands, in single or double precision, and reports whether one of eight selectable compare predicates holds. The comparison is quiet. Every operand pair falls into exactly one of four outcomes: less, equal, greater, or unordered, which occurs when either operand is a NaN. A 3-bit condition code then picks which outcomes make the predicate true.

Besides the one-bit result, the block returns a rewritten copy of a 32-bit floating-point status and control word. The result is placed in bit 29. Bits 31, 30 and 28 are cleared, and bits 27 down to 0 pass through unchanged. Both outputs are registered, so a compare issued in one cycle is visible after the next rising clock edge.

Top module: `fpcmp_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `flag_out` and `status_out` become 0 at that edge.
- R2: Inputs sampled at a rising edge with `rst_n` high determine both outputs from that edge onward. The outputs do not change between edges.
- R3: An operand is a NaN when its exponent field is all ones and its mantissa is nonzero. Any NaN operand makes the outcome unordered. An infinity (all-ones exponent, zero mantissa) is ordered.
- R4: Positive zero and negative zero compare equal, in both precisions.
- R5: Ordered values, including infinities and subnormals of either sign, compare by sign and then magnitude. Any negative value is less than any positive value. Among negative values, the one with the larger magnitude is less.
- R6: Condition code 0 gives 0 for every outcome. Code 1 gives 1 only for unordered. Code 2 gives 1 only for equal. Code 3 gives 1 for equal or unordered.
- R7: Code 4 gives 1 only for less. Code 5 gives 1 for less or unordered. Code 6 gives 1 for less or equal. Code 7 gives 1 for every outcome except greater.
- R8: Only bits 2:0 of `cond_in` select the predicate. Bit 3 has no effect on either output.
- R9: `status_out` bit 29 equals `flag_out`. Bits 31, 30 and 28 are 0. Bits 27:0 equal `status_in[27:0]` as sampled at the same edge.
- R10: With `dbl_sel` = 0 the operands are single precision: bits 31:0, with sign in bit 31, an 8-bit exponent and a 23-bit mantissa. Bits 63:32 are ignored in this mode. With `dbl_sel` = 1 all 64 bits are used: sign in bit 63, an 11-bit exponent and a 52-bit mantissa.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | First operand (left side of the predicate) |
| op_b | input | 64 | Second operand |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single |
| cond_in | input | 4 | Predicate code in bits 2:0; bit 3 is ignored |
| status_in | input | 32 | Current status and control word |
| flag_out | output | 1 | Registered predicate result |
| status_out | output | 32 | Registered rewritten status word |

## Verification
Each result is due exactly one rising edge after its inputs are presented. The bench drives inputs on the falling edge and samples both outputs on the following falling edge, half a period after the register loads. One directed test samples just after new inputs are applied and before the next rising edge, and confirms that the previous result is still held. The reset check samples on the falling edge after a rising edge taken with `rst_n` low.

// File: rtl/fpcmp_pkg.sv
// Package: shared types for the floating-point compare condition unit.
// Assumes: the outcome encoding below is used consistently by all submodules.
package fpcmp_pkg;

    // Four-way outcome of a quiet comparison
    typedef enum logic [1:0] {
        CMP_LT = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GT = 2'd2,
        CMP_UN = 2'd3
    } cmp_class_t;

    // Predicate code bits: each set bit admits one outcome
    localparam int unsigned PRED_UN_BIT = 0;
    localparam int unsigned PRED_EQ_BIT = 1;
    localparam int unsigned PRED_LT_BIT = 2;
    localparam int unsigned PRED_W      = 3;

    // Single and double precision field widths
    localparam int unsigned SP_EXP_W = 8;
    localparam int unsigned SP_MAN_W = 23;
    localparam int unsigned DP_EXP_W = 11;
    localparam int unsigned DP_MAN_W = 52;

endpackage

// File: rtl/fpcmp_classify.sv
// Module: fpcmp_classify
// Classifies a pair of IEEE-754 values of one format as less, equal,
// greater or unordered (quiet compare). Purely combinational.
// Assumes: operands are raw bit patterns; signed zeros are equal.
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val_a,
    input  logic [EXP_W+MAN_W:0] val_b,
    output cmp_class_t           cls
);
    localparam int unsigned W     = EXP_W + MAN_W + 1;
    localparam int unsigned MAG_W = W - 1;

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             nan_a, nan_b;
    logic             both_zero;

    // Split fields and detect NaN and the all-zero magnitude case
    always_comb begin
        sgn_a     = val_a[W-1];
        sgn_b     = val_b[W-1];
        mag_a     = val_a[MAG_W-1:0];
        mag_b     = val_b[MAG_W-1:0];
        nan_a     = (&val_a[MAG_W-1:MAN_W]) && (|val_a[MAN_W-1:0]);
        nan_b     = (&val_b[MAG_W-1:MAN_W]) && (|val_b[MAN_W-1:0]);
        both_zero = (mag_a == '0) && (mag_b == '0);
    end

    // Decide the outcome by NaN, zero, sign and magnitude in that order
    always_comb begin
        if (nan_a || nan_b) begin
            cls = CMP_UN;
        end else if (both_zero || (val_a == val_b)) begin
            cls = CMP_EQ;
        end else if (sgn_a != sgn_b) begin
            cls = sgn_a ? CMP_LT : CMP_GT;
        end else if (!sgn_a) begin
            cls = (mag_a < mag_b) ? CMP_LT : CMP_GT;
        end else begin
            cls = (mag_a > mag_b) ? CMP_LT : CMP_GT;
        end
    end

endmodule

// File: rtl/fpcmp_predicate.sv
// Module: fpcmp_predicate
// Evaluates a 3-bit predicate code against a compare outcome. Each code
// bit admits one outcome (unordered, equal, less); greater is never admitted.
// Assumes: code is already trimmed to its three meaningful bits.
module fpcmp_predicate
    import fpcmp_pkg::*;
(
    input  cmp_class_t        cls,
    input  logic [PRED_W-1:0] code,
    output logic              hit
);
    // Select the admitting code bit for the present outcome
    always_comb begin
        unique case (cls)
            CMP_UN:  hit = code[PRED_UN_BIT];
            CMP_EQ:  hit = code[PRED_EQ_BIT];
            CMP_LT:  hit = code[PRED_LT_BIT];
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fpcmp_status_merge.sv
// Module: fpcmp_status_merge
// Builds the new status word: flag into its bit, the bits above the
// preserved low field cleared, the low field copied through.
// Assumes: FLAG_POS lies inside the cleared top field above KEEP_W.
module fpcmp_status_merge #(
    parameter int unsigned SW       = 32,
    parameter int unsigned KEEP_W   = 28,
    parameter int unsigned FLAG_POS = 29
) (
    input  logic          flag,
    input  logic [SW-1:0] word_in,
    output logic [SW-1:0] word_out
);
    // Clear the top field, keep the low field, insert the flag
    always_comb begin
        word_out                = '0;
        word_out[KEEP_W-1:0]    = word_in[KEEP_W-1:0];
        word_out[FLAG_POS]      = flag;
    end

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Quiet IEEE-754 compare with selectable predicate, single or double
// precision, and status-word rewrite. Both outputs are registered.
// Assumes: synchronous active-low reset; single precision uses op bits 31:0.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int unsigned OP_W     = 64,
    parameter int unsigned COND_W   = 4,
    parameter int unsigned SW       = 32,
    parameter int unsigned FLAG_POS = 29,
    parameter int unsigned KEEP_W   = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              dbl_sel,
    input  logic [COND_W-1:0] cond_in,
    input  logic [SW-1:0]     status_in,
    output logic              flag_out,
    output logic [SW-1:0]     status_out
);
    localparam int unsigned SP_W = SP_EXP_W + SP_MAN_W + 1;
    localparam int unsigned DP_W = DP_EXP_W + DP_MAN_W + 1;

    cmp_class_t cls_sp, cls_dp, cls_sel;
    logic       hit;
    logic [SW-1:0] word_next;

    fpcmp_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_cls_sp (
        .val_a (op_a[SP_W-1:0]),
        .val_b (op_b[SP_W-1:0]),
        .cls   (cls_sp)
    );

    fpcmp_classify #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_cls_dp (
        .val_a (op_a[DP_W-1:0]),
        .val_b (op_b[DP_W-1:0]),
        .cls   (cls_dp)
    );

    // Pick the outcome of the active precision
    always_comb cls_sel = dbl_sel ? cls_dp : cls_sp;

    fpcmp_predicate u_pred (
        .cls  (cls_sel),
        .code (cond_in[PRED_W-1:0]),
        .hit  (hit)
    );

    fpcmp_status_merge #(.SW(SW), .KEEP_W(KEEP_W), .FLAG_POS(FLAG_POS)) u_merge (
        .flag     (hit),
        .word_in  (status_in),
        .word_out (word_next)
    );

    // Register flag and status word; clear both under reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_out   <= 1'b0;
            status_out <= '0;
        end else begin
            flag_out   <= hit;
            status_out <= word_next;
        end
    end

    // Assertions guarding the registered outputs

    // Low field of the status word follows its input by one cycle
    assert_low_field_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> status_out[KEEP_W-1:0] == $past(status_in[KEEP_W-1:0]));

    // Flag bit mirrors the flag output and the other top bits stay clear
    assert_flag_bit_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_out[FLAG_POS] == flag_out) &&
        ($countones(status_out[SW-1:KEEP_W]) == 32'(flag_out)));

    // The false predicate never yields a set flag
    assert_false_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_in[PRED_W-1:0] == 3'd0) |=> !flag_out);

    // A single-precision NaN under the unordered predicate sets the flag
    assert_sp_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_sel && cond_in[PRED_W-1:0] == 3'd1 &&
         (&op_a[SP_W-2:SP_MAN_W]) && (|op_a[SP_MAN_W-1:0])) |=> flag_out);

    // Signed zeros under the equal predicate set the flag
    assert_sp_zero_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_sel && cond_in[PRED_W-1:0] == 3'd2 &&
         op_a[SP_W-2:0] == '0 && op_b[SP_W-2:0] == '0) |=> flag_out);

    // Less and greater-or-equal predicates never hold together
    assert_lt_code_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_in[PRED_W-1:0] == 3'd4 && dbl_sel && op_a == op_b) |=> !flag_out);

endmodule

// File: tb/test_fpcmp_unit.sv
// Bench for fpcmp_unit: a vector table walked under all eight predicate
// codes, then directed tests for reset, timing and ignored inputs.
module test_fpcmp_unit;

    localparam int LT = 0, EQ = 1, GT = 2, UN = 3;
    localparam int NV = 17;

    typedef struct packed {
        logic        dbl;
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  cls;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h3F800000, 64'h40000000, 2'(LT)},          // R5 1<2
        '{1'b0, 64'h40000000, 64'h3F800000, 2'(GT)},          // R5
        '{1'b0, 64'h3F800000, 64'h3F800000, 2'(EQ)},          // R5
        '{1'b0, 64'h00000000, 64'h80000000, 2'(EQ)},          // R4
        '{1'b0, 64'hBF800000, 64'hC0000000, 2'(GT)},          // R5 -1>-2
        '{1'b0, 64'hBF800000, 64'h3F800000, 2'(LT)},          // R5
        '{1'b0, 64'h7FC00000, 64'h3F800000, 2'(UN)},          // R3
        '{1'b0, 64'h3F800000, 64'h7F800001, 2'(UN)},          // R3
        '{1'b0, 64'h7F800000, 64'h7F7FFFFF, 2'(GT)},          // R3 inf ordered
        '{1'b0, 64'hFF800000, 64'hFF7FFFFF, 2'(LT)},          // R5
        '{1'b1, 64'h3FF0000000000000, 64'h4000000000000000, 2'(LT)}, // R10
        '{1'b1, 64'h8000000000000000, 64'h0000000000000000, 2'(EQ)}, // R4
        '{1'b1, 64'h7FF8000000000000, 64'h0000000000000000, 2'(UN)}, // R3
        '{1'b1, 64'h3FF0000000000000, 64'h3FF0000000000001, 2'(LT)}, // R10
        '{1'b0, 64'hDEADBEEF3F800000, 64'h000000003F800000, 2'(EQ)}, // R10
        '{1'b1, 64'hDEADBEEF3F800000, 64'h000000003F800000, 2'(LT)}, // R10
        '{1'b0, 64'h00000001, 64'h00000000, 2'(GT)}           // R5 subnormal
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        dbl_sel = 1'b0;
    logic [3:0]  cond_in = '0;
    logic [31:0] status_in = '0;
    logic        flag_out;
    logic [31:0] status_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fpcmp_unit i_fpcmp_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .dbl_sel(dbl_sel), .cond_in(cond_in), .status_in(status_in),
        .flag_out(flag_out), .status_out(status_out)
    );

    // Predicate truth from R6/R7
    function automatic logic pred(int cls, int code);
        case (code)
            0: return 1'b0;
            1: return cls == UN;
            2: return cls == EQ;
            3: return cls == EQ || cls == UN;
            4: return cls == LT;
            5: return cls == LT || cls == UN;
            6: return cls == LT || cls == EQ;
            default: return cls != GT;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic d, logic [63:0] a, logic [63:0] b,
                         logic [3:0] c, logic [31:0] s);
        @(negedge clk);
        dbl_sel = d; op_a = a; op_b = b; cond_in = c; status_in = s;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] sw;
        logic        e;
        // R1: reset state
        op_a = 64'h7FC00000; cond_in = 4'd7; status_in = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        check("R1 flag", {31'b0, flag_out}, 32'h0);
        check("R1 status", status_out, 32'h0);
        rst_n = 1'b1;

        // Table walk: every vector under all eight codes (R3-R7, R9, R10)
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < 8; k++) begin
                sw = 32'hF0000000 ^ (32'(i) * 32'h01234567) ^ 32'(k << 24);
                e  = pred(int'(VECS[i].cls), k);
                apply(VECS[i].dbl, VECS[i].a, VECS[i].b,
                      {1'(i[0] ^ k[0]), 3'(k)}, sw);
                check($sformatf("R6_R7 flag vec%0d code%0d", i, k),
                      {31'b0, flag_out}, {31'b0, e});
                check($sformatf("R9 status vec%0d code%0d", i, k),
                      status_out, {2'b00, e, 1'b0, sw[27:0]});
            end
        end

        // R8: bit 3 of the code makes no difference
        apply(1'b0, 64'h40000000, 64'h3F800000, 4'b1100, 32'h0);
        check("R8 code 12 on greater", {31'b0, flag_out}, 32'h0);
        apply(1'b0, 64'h3F800000, 64'h40000000, 4'b1000, 32'h0);
        check("R8 code 8 on less", {31'b0, flag_out}, 32'h0);
        apply(1'b0, 64'h7FC00000, 64'h0, 4'b1001, 32'h0);
        check("R8 code 9 on unordered", {31'b0, flag_out}, 32'h1);

        // R2: previous result held until the next rising edge
        apply(1'b0, 64'h0, 64'h0, 4'd2, 32'h0FFFFFFF);
        check("R2 settled", status_out, 32'h2FFFFFFF);
        op_a = 64'h7FC00000; status_in = 32'h00000005;
        #1;
        check("R2 held flag", {31'b0, flag_out}, 32'h1);
        check("R2 held status", status_out, 32'h2FFFFFFF);
        @(negedge clk);
        check("R2 updated", status_out, 32'h00000005);

        // R10: single mode ignores a NaN pattern in the upper half
        apply(1'b0, 64'h7FF8000000000000, 64'h0, 4'd2, 32'h0);
        check("R10 upper half ignored", {31'b0, flag_out}, 32'h1);

        // R1: reset reasserted mid-run clears outputs
        apply(1'b0, 64'h0, 64'h0, 4'd7, 32'h0ABCDEF0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", status_out, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule